// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one programmable logic cell. Six literal inputs feed an AND plane with eight product terms. For each term, every literal can be used in true form, used in complemented form, or left out. An OR stage adds up the product terms that are switched on, along with two extra inputs that do not pass through the AND plane. The cell drives one output. That output is either the OR result directly, or the OR result after a rising-edge D flip-flop. A one-bit mode setting picks between the two.

All settings are held in a 107-bit shift chain. The chain is loaded one bit per clock while the configure enable is high, and the first bit shifted in is the most significant bit. While the chain is loading, the output is forced low and the flip-flop is cleared. Once the enable drops, the configuration stays fixed and the cell evaluates its inputs. This lets a function such as ab + bc' + g + h be built by loading the matching pattern.

Top module: `cpld_macrocell`

## Requirements
- R1: Each literal in each term has a two-bit field. Bit 0 of the field means "literal must be 1" and bit 1 means "literal must be 0". Code 00 leaves the literal out, 01 uses it in true form, 10 uses it in complemented form, and 11 forces the term to 0.
- R2: A product term whose six fields are all 00 evaluates to 1.
- R3: A product term adds to the sum only when its OR-enable bit is 1. When its bit is 0, it has no effect on f_out. When no term and no extra input is enabled, the sum is 0.
- R4: Extra input j is ORed into the sum directly when its enable bit is 1.
- R5: When cfg_en is high, each rising edge shifts cfg_din into chain bit 0 and moves every other bit up by one place. Data is sent MSB first. The chain layout is:
  - bit 0: output mode
  - bit 1+j: enable for extra input j
  - bit 3+t: OR-enable for product term t
  - bits 11+2*(6t+i) and 12+2*(6t+i): the field of literal i in term t
- R6: While cfg_en is high, f_out is 0, and the flip-flop is cleared at every rising edge.
- R7: When the mode bit is 0, f_out equals the OR sum in the same cycle.
- R8: When the mode bit is 1, f_out is the OR sum captured at the previous rising edge.
- R9: A high rst at a rising edge clears the flip-flop and the whole configuration chain, so f_out is 0 afterwards.
- R10: When cfg_en is low, the chain keeps its contents, and cfg_din has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| lit_in | input | 6 | Literal inputs to the AND plane |
| xtra_in | input | 2 | Extra inputs that go straight to the OR stage |
| f_out | output | 1 | Cell output, registered or combinational |

## Verification
The assertions assume that rst, cfg_en, cfg_din and the data inputs are stable around each rising edge. They also assume that the mode bit only changes through the chain. The stimulus meets these assumptions by changing every input one time unit after a rising edge and by reading f_out on the falling edge. The check that a registered value equals the previous sum relies on consecutive edges with no reset in between. For this reason, resets in the bench are applied only at cycle boundaries, and the expected value is recomputed afterwards.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int N_LIT     = 6;
  localparam int N_XTRA    = 2;
  localparam int N_PT      = 8;
  localparam int FLD_W     = 2;
  localparam int TERM_W    = N_LIT * FLD_W;
  localparam int PLANE_W   = N_PT * TERM_W;
  localparam int OFS_XEN   = 1;
  localparam int OFS_PEN   = OFS_XEN + N_XTRA;
  localparam int OFS_PLANE = OFS_PEN + N_PT;
  localparam int CFG_W     = OFS_PLANE + PLANE_W;

  // Product term: each field bit vetoes one polarity of its literal.
  function automatic logic term_value(input logic [TERM_W-1:0] fld,
                                      input logic [N_LIT-1:0]  lit);
    logic v;
    v = 1'b1;
    for (int i = 0; i < N_LIT; i++) begin
      if (fld[FLD_W*i]   && !lit[i]) v = 1'b0;
      if (fld[FLD_W*i+1] &&  lit[i]) v = 1'b0;
    end
    return v;
  endfunction

  function automatic logic or_sum(input logic [N_PT-1:0]   pt,
                                  input logic [N_PT-1:0]   pen,
                                  input logic [N_XTRA-1:0] x,
                                  input logic [N_XTRA-1:0] xen);
    return (|(pt & pen)) | (|(x & xen));
  endfunction
endpackage

// File: rtl/mc_cfg_chain.sv
module mc_cfg_chain #(
  parameter int W = mc_pkg::CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (shift_en) cfg_q <= {cfg_q[W-2:0], din};
  end

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (cfg_q[0] == $past(din)) && (cfg_q[W-1:1] == $past(cfg_q[W-2:0])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg_q));
endmodule

// File: rtl/mc_and_plane.sv
module mc_and_plane #(
  parameter int N_LIT = mc_pkg::N_LIT,
  parameter int N_PT  = mc_pkg::N_PT,
  localparam int TW   = N_LIT * mc_pkg::FLD_W
) (
  input  logic [N_PT*TW-1:0] plane,
  input  logic [N_LIT-1:0]   lit,
  output logic [N_PT-1:0]    pt
);
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = mc_pkg::term_value(plane[t*TW +: TW], lit);
  end
endmodule

// File: rtl/mc_or_stage.sv
module mc_or_stage #(
  parameter int N_PT   = mc_pkg::N_PT,
  parameter int N_XTRA = mc_pkg::N_XTRA
) (
  input  logic [N_PT-1:0]   pt,
  input  logic [N_PT-1:0]   pen,
  input  logic [N_XTRA-1:0] x,
  input  logic [N_XTRA-1:0] xen,
  output logic              sum
);
  assign sum = mc_pkg::or_sum(pt, pen, x, xen);
endmodule

// File: rtl/mc_out_reg.sv
module mc_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic sum,
  input  logic reg_sel,
  output logic q,
  output logic f_out
);
  always_ff @(posedge clk) begin
    if (rst || hold) q <= 1'b0;
    else             q <= sum;
  end

  assign f_out = hold ? 1'b0 : (reg_sel ? q : sum);

  // R6
  out_low_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !f_out);

  // R6
  ff_clear_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !q);

  // R8
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !rst) |=> (q == $past(sum)));
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell #(
  parameter int N_LIT  = mc_pkg::N_LIT,
  parameter int N_XTRA = mc_pkg::N_XTRA,
  parameter int N_PT   = mc_pkg::N_PT,
  localparam int CW    = 1 + N_XTRA + N_PT + N_PT * N_LIT * mc_pkg::FLD_W,
  localparam int O_XEN = 1,
  localparam int O_PEN = O_XEN + N_XTRA,
  localparam int O_PL  = O_PEN + N_PT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [N_LIT-1:0]  lit_in,
  input  logic [N_XTRA-1:0] xtra_in,
  output logic              f_out
);
  logic [CW-1:0]     cfg_q;
  logic [N_PT-1:0]   pt;
  logic [N_PT-1:0]   pen;
  logic [N_XTRA-1:0] xen;
  logic              reg_sel;
  logic              sum;
  logic              ff_q;

  assign reg_sel = cfg_q[0];
  assign xen     = cfg_q[O_XEN +: N_XTRA];
  assign pen     = cfg_q[O_PEN +: N_PT];

  mc_cfg_chain #(.W(CW)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .din(cfg_din), .cfg_q(cfg_q)
  );

  mc_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_and (
    .plane(cfg_q[CW-1:O_PL]), .lit(lit_in), .pt(pt)
  );

  mc_or_stage #(.N_PT(N_PT), .N_XTRA(N_XTRA)) u_or (
    .pt(pt), .pen(pen), .x(xtra_in), .xen(xen), .sum(sum)
  );

  mc_out_reg u_out (
    .clk(clk), .rst(rst), .hold(cfg_en), .sum(sum), .reg_sel(reg_sel),
    .q(ff_q), .f_out(f_out)
  );

  // R7
  comb_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !reg_sel) |-> (f_out == sum));

  // R3
  empty_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (pen == '0 && xen == '0) |-> !sum);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ff_q && cfg_q == '0));
endmodule

// File: tb/sim_cpld_macrocell.sv
module sim_cpld_macrocell;
  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [5:0] lit_in = '0;
  logic [1:0] xtra_in = '0;
  logic       f_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  item_t sb[$];

  logic [1:0] fld [8][6];
  logic [7:0] pen;
  logic [1:0] xen;
  logic       rsel;
  logic       prev;

  always #2 clk = ~clk;

  cpld_macrocell u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lit_in(lit_in), .xtra_in(xtra_in), .f_out(f_out)
  );

  // Monitor: one expected item per cycle, compared at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (f_out !== it.exp) begin
        fails++;
        $display("FAIL %s: f_out=%b expected=%b", it.tag, f_out, it.exp);
      end
    end
  end

  function automatic logic model(input logic [5:0] l, input logic [1:0] x);
    logic s;
    s = |(x & xen);
    for (int t = 0; t < 8; t++) begin
      logic hit;
      hit = 1'b1;
      for (int i = 0; i < 6; i++) begin
        case (fld[t][i])
          2'b00:   ;
          2'b01:   if (l[i] != 1'b1) hit = 1'b0;
          2'b10:   if (l[i] != 1'b0) hit = 1'b0;
          default: hit = 1'b0;
        endcase
      end
      if (pen[t] && hit) s = 1'b1;
    end
    return s;
  endfunction

  task automatic clear_cfg();
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 6; i++) fld[t][i] = 2'b00;
    pen = '0; xen = '0; rsel = 1'b0;
  endtask

  // Loads the bench config through the chain; R5 layout, R6 output low.
  task automatic load_cfg();
    logic [106:0] v;
    v = '0;
    v[0] = rsel;
    for (int j = 0; j < 2; j++) v[1+j] = xen[j];
    for (int t = 0; t < 8; t++) v[3+t] = pen[t];
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 6; i++) v[11+2*(6*t+i) +: 2] = fld[t][i];
    for (int b = 106; b >= 0; b--) begin
      @(posedge clk); #1;
      cfg_en = 1'b1; cfg_din = v[b];
      sb.push_back('{1'b0, "R6"});
    end
    @(posedge clk); #1;
    cfg_en = 1'b0; cfg_din = 1'b0; lit_in = '0; xtra_in = '0;
    prev = model(6'd0, 2'd0);
    sb.push_back('{rsel ? 1'b0 : prev, "R6"});
  endtask

  // Driver: toggles cfg_din too, which must be ignored (R10).
  task automatic apply(input logic [5:0] l, input logic [1:0] x, input string tag);
    logic e;
    @(posedge clk); #1;
    lit_in = l; xtra_in = x; cfg_din = l[0] ^ x[1];
    if (rsel) begin
      e = prev;
      prev = model(l, x);
    end else begin
      e = model(l, x);
    end
    sb.push_back('{e, tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    prev = 1'b0;
    // R9: output low out of reset
    repeat (3) begin
      @(posedge clk); #1;
      sb.push_back('{1'b0, "R9"});
    end
    rst = 1'b0;

    // f = ab + bc' + g + h, combinational (R1 R4 R5 R7 R10)
    fld[0][0] = 2'b01; fld[0][1] = 2'b01;
    fld[1][1] = 2'b01; fld[1][2] = 2'b10;
    pen = 8'b0000_0011; xen = 2'b11; rsel = 1'b0;
    load_cfg();
    for (int k = 0; k < 256; k++) apply(k[5:0], k[7:6], "R7");

    // Same function, registered (R8)
    rsel = 1'b1;
    load_cfg();
    for (int k = 0; k < 96; k++) apply(6'(k * 37 + 5), 2'(k * 3), "R8");

    // Reload mid-operation clears the flip-flop (R6)
    load_cfg();
    apply(6'b000011, 2'b00, "R8");
    apply(6'b000000, 2'b00, "R8");

    // All don't-care term enabled gives constant 1 (R2)
    clear_cfg();
    pen = 8'b0000_0100;
    load_cfg();
    for (int k = 0; k < 32; k++) apply(6'(k * 11), 2'(k), "R2");

    // Code 11 kills a term; disabled term ignored (R1 R3)
    clear_cfg();
    fld[0][0] = 2'b11; pen[0] = 1'b1;
    fld[5][3] = 2'b01;
    load_cfg();
    for (int k = 0; k < 64; k++) apply(k[5:0], 2'b11, "R3");

    // Only extra input 1 enabled: f = x[1] (R4)
    clear_cfg();
    xen = 2'b10;
    load_cfg();
    for (int k = 0; k < 16; k++) apply(6'(k * 7), 2'(k), "R4");

    // Synchronous reset in registered mode clears flip-flop and chain (R9)
    clear_cfg();
    fld[0][4] = 2'b01; pen = 8'b1; rsel = 1'b1;
    load_cfg();
    apply(6'b010000, 2'b00, "R8");
    apply(6'b010000, 2'b00, "R8");
    @(posedge clk); #1;
    rst = 1'b1;
    sb.push_back('{prev, "R9"});
    @(posedge clk); #1;
    rst = 1'b0;
    sb.push_back('{1'b0, "R9"});
    clear_cfg();
    prev = 1'b0;
    for (int k = 0; k < 4; k++) apply(6'h3F, 2'b11, "R9");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule